// File: doc/BRIEF.md
# DRAM Row/Column Burst Controller

This controller connects a simple requester to a DRAM device that shares one set of address pins between the row phase and the column phase. A request carries a 22-bit word address, a direction and a burst length. The controller opens the row and puts the upper 11 address bits on the pins with the row strobe. It then issues column strobes: the first one carries the lower 11 bits, and each later one carries the next column. The same row stays open for the whole burst, and the column wraps within that row.

On reads, each word comes back on the shared data pins a fixed number of cycles after its column strobe. The controller captures it and hands it to the requester. On writes, the controller drives the data pins during each column strobe. It pulses a pull signal so the requester can present the next word. A refresh timer marks one row as due for refresh once per interval. That row is opened and closed with no column strobe. The refresh runs only between bursts, and the request port reports not ready while one is due or running.

Top module: `dram_burst_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the row strobe, column strobe, output enable and write enable are low, rd_valid is low and req_ready is high.
- R2: When a request is accepted, the row strobe rises with address bits [21:11] on dram_addr. That row is the one in use for every column strobe of the burst.
- R3: The first column strobe of a burst comes exactly T_RCD cycles after the row strobe rises. It carries address bits [10:0].
- R4: A burst with req_len = n makes exactly n+1 column strobes on consecutive cycles. The row strobe stays high throughout, and no column strobe occurs while the row strobe is low.
- R5: For a read, each word is presented on rd_data with rd_valid exactly T_CL+1 cycles after its column strobe, in column order. Each word equals the contents of the addressed cell.
- R6: For a write, each column strobe carries dram_we and the controller drives wr_data onto dram_dq. wr_next pulses in exactly those cycles, so the word present at a pulse belongs to that beat.
- R7: dram_oe and dram_we are never high together, and neither is high without a column strobe.
- R8: After the row strobe falls, it stays low for at least T_RP cycles before it rises again.
- R9: A refresh is a row strobe period with no column strobe. Refreshed rows follow the sequence 0, 1, 2, ... and wrap from 2047 to 0.
- R10: One refresh becomes due every REF_INTERVAL cycles. It starts only when no burst is open, so a burst is never split.
- R11: Within a burst, each column address is the previous one plus one, modulo 2^11, so a burst that reaches column 2047 continues at column 0 of the same row.
- R12: req_ready is low while a row is open, during precharge and while a refresh is due. A request offered then is held and is accepted only once req_ready returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 22 | Word address: row in [21:11], start column in [10:0] |
| req_len | input | 4 | Burst length minus one |
| wr_data | input | 16 | Current write word |
| wr_next | output | 1 | Current write word taken; present the next |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |
| dram_ras | output | 1 | Row strobe, active high |
| dram_cas | output | 1 | Column strobe, active high |
| dram_oe | output | 1 | Read select |
| dram_we | output | 1 | Write select |
| dram_addr | output | 11 | Shared row/column address pins |
| dram_dq | inout | 16 | Shared data pins |

## Verification
Two events can fall in the same cycle: the refresh timer expiring and a burst being requested or already running. Back-to-back random bursts of random length are sent over tens of thousands of cycles, so many refresh deadlines land inside an open burst or on the cycle a request is offered. The bench checks that every burst still shows its full count of consecutive column strobes under one row strobe. It checks that each refresh follows as a separate strobe period with no column strobe and the next row in sequence, and that the number of refreshes keeps pace with elapsed time. It also confirms that no request is accepted while a row is open.

// File: rtl/drb_pkg.sv
package drb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BEAT,
    ST_RFSH,
    ST_CLOSE
  } drb_state_t;
endpackage

// File: rtl/drb_refresh_sched.sv
module drb_refresh_sched #(
  parameter int ROW_W    = 11,
  parameter int INTERVAL = 780
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = (cnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)       pending <= 1'b1;
      else if (grant) pending <= 1'b0;
      if (grant)      row <= row + 1'b1;
    end
  end

  // R10
  grant_when_due_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> pending);
endmodule

// File: rtl/drb_col_walker.sv
module drb_col_walker #(
  parameter int COL_W = 11,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic             last
);
  logic [LEN_W-1:0] remain;

  assign last = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      remain <= '0;
    end else if (load) begin
      col    <= start_col;
      remain <= len;
    end else if (step) begin
      col    <= col + 1'b1;
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/drb_read_capture.sv
module drb_read_capture #(
  parameter int DATA_W = 16,
  parameter int T_CL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [T_CL:0] tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      tag[0]   <= issue;
      rd_valid <= tag[T_CL];
      if (tag[T_CL]) rd_data <= dq_in;
    end
  end

  for (genvar i = 1; i <= T_CL; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tag[i] <= 1'b0;
      else     tag[i] <= tag[i-1];
    end
  end
endmodule

// File: rtl/dram_burst_ctrl.sv
module dram_burst_ctrl
  import drb_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 16,
  parameter int LEN_W        = 4,
  parameter int T_RCD        = 2,
  parameter int T_CL         = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     wr_next,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     dram_ras,
  output logic                     dram_cas,
  output logic                     dram_oe,
  output logic                     dram_we,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  inout  wire  [DATA_W-1:0]        dram_dq
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int WMAX   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int WAIT_W = (WMAX > 1) ? $clog2(WMAX + 1) : 1;
  localparam logic [WAIT_W-1:0] RCD_INIT = WAIT_W'(T_RCD - 1);
  localparam logic [WAIT_W-1:0] RP_INIT  = WAIT_W'(T_RP - 1);

  drb_state_t        state;
  logic [WAIT_W-1:0] wcnt;
  logic              wr_op;
  logic              ras_q, cas_q, oe_q, we_q, drv_q, wr_next_q;
  logic [PIN_W-1:0]  addr_q;
  logic [DATA_W-1:0] dq_q;

  logic              ref_pend, ref_grant;
  logic [ROW_W-1:0]  ref_row;
  logic [COL_W-1:0]  col;
  logic              col_last;
  logic              accept, beat_go;

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign ref_grant = (state == ST_IDLE) && ref_pend;
  assign beat_go   = ((state == ST_OPEN) && (wcnt == '0)) || (state == ST_BEAT);

  drb_refresh_sched #(.ROW_W(ROW_W), .INTERVAL(REF_INTERVAL)) i_refresh (
    .clk(clk), .rst(rst), .grant(ref_grant), .pending(ref_pend), .row(ref_row)
  );

  drb_col_walker #(.COL_W(COL_W), .LEN_W(LEN_W)) i_walker (
    .clk(clk), .rst(rst), .load(accept), .start_col(req_addr[COL_W-1:0]),
    .len(req_len), .step(beat_go), .col(col), .last(col_last)
  );

  drb_read_capture #(.DATA_W(DATA_W), .T_CL(T_CL)) i_capture (
    .clk(clk), .rst(rst), .issue(beat_go && !wr_op), .dq_in(dram_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      wr_op     <= 1'b0;
      ras_q     <= 1'b0;
      cas_q     <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      drv_q     <= 1'b0;
      wr_next_q <= 1'b0;
      addr_q    <= '0;
      dq_q      <= '0;
    end else begin
      cas_q     <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      drv_q     <= 1'b0;
      wr_next_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_grant) begin
            state  <= ST_RFSH;
            ras_q  <= 1'b1;
            addr_q <= PIN_W'(ref_row);
            wcnt   <= RCD_INIT;
          end else if (accept) begin
            state  <= ST_OPEN;
            ras_q  <= 1'b1;
            addr_q <= PIN_W'(req_addr[ADDR_W-1:COL_W]);
            wcnt   <= RCD_INIT;
            wr_op  <= req_write;
          end
        end
        ST_OPEN: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else if (col_last) begin
            state <= ST_CLOSE;
            wcnt  <= RP_INIT;
          end else begin
            state <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (col_last) begin
            state <= ST_CLOSE;
            wcnt  <= RP_INIT;
          end
        end
        ST_RFSH: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else begin
            state <= ST_CLOSE;
            wcnt  <= RP_INIT;
          end
        end
        ST_CLOSE: begin
          ras_q <= 1'b0;
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else            state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (beat_go) begin
        cas_q  <= 1'b1;
        addr_q <= PIN_W'(col);
        if (wr_op) begin
          we_q      <= 1'b1;
          drv_q     <= 1'b1;
          dq_q      <= wr_data;
          wr_next_q <= 1'b1;
        end else begin
          oe_q <= 1'b1;
        end
      end
    end
  end

  assign dram_ras  = ras_q;
  assign dram_cas  = cas_q;
  assign dram_oe   = oe_q;
  assign dram_we   = we_q;
  assign dram_addr = addr_q;
  assign wr_next   = wr_next_q;
  assign dram_dq   = drv_q ? dq_q : {DATA_W{1'bz}};

  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dram_oe && dram_we) && ((dram_oe || dram_we) -> dram_cas));

  // R4
  cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    dram_cas |-> dram_ras);

  // R11
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dram_cas && $past(dram_cas)) |-> (dram_addr == PIN_W'($past(dram_addr) + 1'b1)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dram_ras && !dram_cas && !rd_valid));
endmodule

// File: tb/test_dram_burst_ctrl.sv
`timescale 1ns/1ps
module test_dram_burst_ctrl;
  localparam int T_RCD   = 2;
  localparam int T_CL    = 2;
  localparam int T_RP    = 2;
  localparam int REF_INT = 48;
  localparam int DW      = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready, wr_next, rd_valid;
  logic [21:0]   req_addr = '0;
  logic [3:0]    req_len = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic          dram_ras, dram_cas, dram_oe, dram_we;
  logic [10:0]   dram_addr;
  wire  [DW-1:0] dram_dq;

  dram_burst_ctrl #(.T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .REF_INTERVAL(REF_INT))
  i_dram_burst_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_next(wr_next), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_oe(dram_oe), .dram_we(dram_we),
    .dram_addr(dram_addr), .dram_dq(dram_dq)
  );

  int cyc = 0;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic logic [DW-1:0] init_word(int key);
    return DW'(key) ^ 16'h5A3C;
  endfunction

  // expectations shared with the device model
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_rd [$];
  logic [DW-1:0] exp_wq [$];
  logic [10:0]   exp_row, exp_col0;
  int            exp_len;
  bit            burst_busy = 1'b0;

  // device model and pin checks
  int            m_chk = 0, m_err = 0;
  logic [DW-1:0] mem [int];
  logic [DW-1:0] mp [T_CL+1];
  logic [T_CL:0] mp_v = '0;
  int            rd_cas_cyc [$];
  logic          ras_d = 1'b0, cas_seen = 1'b0;
  logic [10:0]   open_row = '0, exp_ref_row = '0;
  int            bi = 0, low_cnt = T_RP, rise_cyc = 0, ref_cnt = 0;

  assign dram_dq = mp_v[T_CL] ? mp[T_CL] : {DW{1'bz}};

  task automatic mchk(bit ok, string req, int act, int expv);
    m_chk++;
    if (!ok) begin
      m_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      mp_v = '0;
    end else begin
      int key;
      logic [DW-1:0] rv;
      for (int i = T_CL; i > 0; i--) begin
        mp[i]   = mp[i-1];
        mp_v[i] = mp_v[i-1];
      end
      mp_v[0] = 1'b0;
      if (req_valid && req_ready) mchk(!dram_ras, "R12 accept while row open", 1, 0);
      if (dram_oe || dram_we || wr_next)
        mchk(dram_cas && !(dram_oe && dram_we) && (wr_next == dram_we), "R7 strobe select", {dram_cas, dram_oe, dram_we}, 3'b110);
      if (dram_ras && !ras_d) begin
        mchk(low_cnt >= T_RP, "R8 precharge gap", low_cnt, T_RP);
        open_row = dram_addr; cas_seen = 1'b0; bi = 0; rise_cyc = cyc;
      end
      if (dram_cas) begin
        mchk(dram_ras, "R4 column strobe inside row", 0, 1);
        if (!cas_seen) begin
          mchk(open_row == exp_row, "R2 row on pins", open_row, exp_row);
          mchk(cyc - rise_cyc == T_RCD, "R3 row to column delay", cyc - rise_cyc, T_RCD);
        end
        mchk(dram_addr == 11'(exp_col0 + bi), "R11 column sequence", dram_addr, 11'(exp_col0 + bi));
        cas_seen = 1'b1;
        key = {open_row, dram_addr};
        if (dram_we) begin
          mchk(dram_dq == exp_wq[0], "R6 write data on pins", dram_dq, exp_wq[0]);
          void'(exp_wq.pop_front());
          mem[key] = dram_dq;
        end else if (dram_oe) begin
          rv = mem.exists(key) ? mem[key] : init_word(key);
          mp[0] = rv; mp_v[0] = 1'b1;
          rd_cas_cyc.push_back(cyc);
        end
        bi++;
      end
      if (rd_valid) begin
        mchk(exp_rd.size() > 0 && rd_data == exp_rd[0], "R5 read word", rd_data, exp_rd.size() > 0 ? exp_rd[0] : 0);
        mchk(rd_cas_cyc.size() > 0 && cyc - rd_cas_cyc[0] == T_CL + 1, "R5 read latency",
             rd_cas_cyc.size() > 0 ? cyc - rd_cas_cyc[0] : -1, T_CL + 1);
        if (exp_rd.size() > 0) void'(exp_rd.pop_front());
        if (rd_cas_cyc.size() > 0) void'(rd_cas_cyc.pop_front());
      end
      if (!dram_ras && ras_d) begin
        if (!cas_seen) begin
          mchk(open_row == exp_ref_row, "R9 refresh row order", open_row, exp_ref_row);
          exp_ref_row = exp_ref_row + 1'b1;
          ref_cnt++;
        end else begin
          mchk(bi == exp_len + 1, "R4 R10 beats per burst", bi, exp_len + 1);
          burst_busy = 1'b0;
        end
        low_cnt = 0;
      end
      if (!dram_ras) low_cnt++;
      ras_d = dram_ras;
    end
  end

  // bench-side checks
  int b_chk = 0, b_err = 0;
  task automatic bchk(bit ok, string req, int act, int expv);
    b_chk++;
    if (!ok) begin
      b_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_burst(bit wr, logic [21:0] a, logic [3:0] n);
    logic [DW-1:0] w [16];
    logic [10:0] row, col0;
    int widx, key, waited;
    row = a[21:11]; col0 = a[10:0];
    for (int i = 0; i <= int'(n); i++) begin
      key = {row, 11'(col0 + i)};
      if (wr) begin
        w[i] = DW'($urandom);
        shadow[key] = w[i];
        exp_wq.push_back(w[i]);
      end else begin
        exp_rd.push_back(shadow.exists(key) ? shadow[key] : init_word(key));
      end
    end
    exp_row = row; exp_col0 = col0; exp_len = int'(n); burst_busy = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = n;
    wr_data = wr ? w[0] : '0; widx = 0; waited = 0;
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (wr && wr_next) begin
        widx++;
        if (widx <= int'(n)) wr_data = w[widx];
      end
      if (!burst_busy && (wr ? (widx == int'(n) + 1) : (exp_rd.size() == 0))) break;
      @(negedge clk);
    end
    if (wr) bchk(widx == int'(n) + 1, "R6 write word pulls", widx, int'(n) + 1);
  endtask

  // offer a request while a refresh is due and confirm it waits
  task automatic blocked_request;
    int held;
    while (!(i_dram_burst_ctrl.req_ready === 1'b1 && cyc % REF_INT == REF_INT - 3)) @(negedge clk);
    held = ref_cnt;
    repeat (4) @(negedge clk);
    run_burst(1'b0, 22'h1F_0003, 4'd2);
    bchk(ref_cnt >= held + 1, "R12 R10 refresh runs before held request", ref_cnt, held + 1);
  endtask

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk);
    bchk({dram_ras, dram_cas, dram_oe, dram_we, rd_valid} == 5'b0, "R1 reset outputs", {dram_ras, dram_cas, dram_oe, dram_we, rd_valid}, 0);
    bchk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    bchk({dram_ras, dram_cas, rd_valid} == 3'b0 && req_ready, "R1 first cycle idle", {dram_ras, dram_cas, rd_valid, req_ready}, 1);
    // directed corners
    run_burst(1'b1, {11'd5, 11'd100}, 4'd0);
    run_burst(1'b0, {11'd5, 11'd100}, 4'd0);
    run_burst(1'b1, {11'd7, 11'd2040}, 4'd15);   // wraps inside row (R11)
    run_burst(1'b0, {11'd7, 11'd2040}, 4'd15);
    run_burst(1'b0, {11'd2047, 11'd2047}, 4'd3);
    run_burst(1'b0, {11'd9, 11'd0}, 4'd15);
    blocked_request();
    // random traffic until the refresh row counter has wrapped
    while (ref_cnt < 2050) begin
      logic [21:0] a;
      a = {11'($urandom % 4), 11'($urandom)};
      run_burst(1'($urandom % 2), a, 4'($urandom % 16));
    end
    bchk(ref_cnt >= 2049, "R9 refresh row wrap reached", ref_cnt, 2049);
    bchk(ref_cnt <= cyc / REF_INT && ref_cnt >= cyc / REF_INT - 2, "R10 refresh cadence", ref_cnt, cyc / REF_INT);
    repeat (8) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", b_err + m_err, b_chk + m_chk);
    $finish;
  end

  initial begin : watchdog
    process::self().srandom(32'd4242);
    repeat (195000) @(posedge clk);
    b_chk++;
    b_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", b_err + m_err, b_chk + m_chk);
    $finish;
  end
endmodule